// File: doc/BRIEF.md
# Squared-Rotation QR Result Rescaler

After one square-root-free QR decomposition step, the triangular factor and the orthogonal factor both carry a per-index scale. For each index i, the diagonal term of the triangular factor holds the square of the eigenvalue estimate instead of the estimate itself. Every other term in that row of the triangular factor is the true value times the estimate. Every term in column i of the orthogonal factor is also the true value times the estimate. If these scales are fed into the next QR-algorithm iteration, fixed-point values overflow quickly. This block removes the scales one index at a time. It multiplies each term belonging to index i by the reciprocal square root of that index's diagonal term. The diagonal then becomes the eigenvalue estimate, and every other term returns to its unscaled value.

Terms arrive as a stream with a valid/ready handshake, 2N terms per index. The block obtains the reciprocal square root from an external unit through a one-cycle request and a one-cycle response. The block keeps that factor in a register for the whole group of 2N terms. One multiplier, with multiplexed operands, serves every term of the group. Results are rounded and saturated. An index whose diagonal is not positive is passed through unchanged and raises an error flag. A one-cycle pulse marks the end of each complete matrix.

Top module: `sgr_rescale`

## Requirements
- R1: Each index takes exactly 2N input beats, and results leave in the same order as the inputs. The beats are: first the diagonal term of the triangular factor; then the other N-1 terms of that row in ascending column order; then the N terms of the orthogonal factor's column in ascending row order. Indices run from 0 to N-1 within a matrix.
- R2: For a positive diagonal d with factor f returned by the reciprocal-square-root unit, the first output beat of the index is d*f, rounded and saturated as R6 and R7 describe.
- R3: For a positive diagonal, each of the remaining 2N-1 beats of the index is the input times the same f, with the same rounding and saturation.
- R4: For each index whose diagonal is positive, exactly one request is issued, carrying that diagonal as its argument. The request lasts one cycle. While the request is pending, no input is accepted.
- R5: A diagonal that is zero or negative (sign bit set) issues no request, and all 2N beats of that index pass through unchanged. The error output goes high in the cycle after such a diagonal is accepted. It stays high until the diagonal of the next matrix's index 0 is accepted. At that point it takes that diagonal's status.
- R6: Values are two's complement, W bits wide, with F fractional bits. A product is rounded by adding 2^(F-1) to the full product and then shifting right arithmetically by F. Exact halves therefore round toward plus infinity.
- R7: A rounded result above 2^(W-1)-1 is output as 2^(W-1)-1. A result below -(2^(W-1)-1) is output as -(2^(W-1)-1). Values never wrap.
- R8: The done output is high for exactly one cycle. That cycle is the one right after the last output beat of index N-1 is taken (out_valid and out_ready both high).
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change. No beat is lost or repeated.
- R10: After reset: out_valid, done, err and isr_req are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input term valid |
| in_ready | output | 1 | Block accepts the input term |
| in_data | input | W | Scaled input term |
| out_valid | output | 1 | Output term valid |
| out_ready | input | 1 | Consumer takes the output term |
| out_data | output | W | Rescaled output term |
| isr_req | output | 1 | One-cycle request for a reciprocal square root |
| isr_arg | output | W | Diagonal term sent with the request |
| isr_rsp_valid | input | 1 | Response strobe from the reciprocal-square-root unit |
| isr_rsp_data | input | W | Reciprocal square root, same fixed-point format |
| err | output | 1 | A non-positive diagonal was seen in the current matrix |
| done | output | 1 | One-cycle end-of-matrix pulse |

## Verification
The bench builds the block with N=3, W=24 and F=12. With these values a whole matrix is 18 beats, so five matrices are enough to reach the following cases. A diagonal term of one LSB gives a factor of 64, which pushes full-scale terms into saturation in both directions. Small odd terms multiplied by a factor of one half land exactly on rounding ties. Zero and negative diagonals can be placed at the first, middle and last index, which exercises the clearing and holding of the error flag across matrix boundaries. The reciprocal-square-root unit is modelled with a fixed 12-cycle response. The output is throttled in a periodic pattern and also held stalled for a long window.

// File: rtl/sgr_rescale_pkg.sv
package sgr_rescale_pkg;

    // Sequencing phases of one index group
    typedef enum logic [2:0] {
        PH_DIAG,   // waiting for the diagonal term
        PH_REQ,    // issuing the reciprocal square root request
        PH_WAIT,   // waiting for the factor
        PH_EMIT,   // emitting the rescaled diagonal
        PH_ROW     // streaming the remaining 2N-1 terms
    } phase_e;

    // Round half toward +inf, then drop fb fractional bits
    function automatic logic signed [63:0] round_half_up(
        input logic signed [63:0] p,
        input int unsigned        fb
    );
        logic signed [63:0] half;
        half = 64'sd1 <<< (fb - 1);
        return (p + half) >>> fb;
    endfunction

endpackage

// File: rtl/sgr_rescale_mul.sv
module sgr_rescale_mul
    import sgr_rescale_pkg::*;
#(
    parameter int W = 24,
    parameter int F = 12
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                pass,
    output logic signed [W-1:0] y
);
    localparam logic signed [63:0] POS_LIM = (64'sd1 <<< (W - 1)) - 64'sd1;
    localparam logic signed [63:0] NEG_LIM = -POS_LIM;

    logic signed [2*W-1:0] prod;
    logic signed [63:0]    wide;
    logic signed [63:0]    rnd;

    // The single shared multiplier of the block
    always_comb begin
        prod = a * b;
        wide = {{(64 - 2*W){prod[2*W-1]}}, prod};
        rnd  = round_half_up(wide, F);
        if (pass)
            y = a;
        else if (rnd > POS_LIM)
            y = POS_LIM[W-1:0];
        else if (rnd < NEG_LIM)
            y = NEG_LIM[W-1:0];
        else
            y = rnd[W-1:0];
    end

endmodule

// File: rtl/sgr_rescale_ctrl.sv
module sgr_rescale_ctrl
    import sgr_rescale_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         slot_free,
    output logic         isr_req,
    output logic [W-1:0] isr_arg,
    input  logic         isr_rsp_valid,
    input  logic [W-1:0] isr_rsp_data,
    output logic [W-1:0] op_a,
    output logic [W-1:0] factor,
    output logic         pass,
    output logic         load,
    output logic         load_last,
    output logic         err
);
    localparam int BEATS = 2 * N;
    localparam int CW    = $clog2(BEATS);
    localparam int IW    = (N > 1) ? $clog2(N) : 1;

    phase_e        phase;
    logic [W-1:0]  diag_q;
    logic [W-1:0]  factor_q;
    logic          pass_q;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic          err_q;

    logic acc;
    logic diag_bad;
    logic beat_end;

    always_comb begin
        in_ready  = (phase == PH_DIAG) || ((phase == PH_ROW) && slot_free);
        acc       = in_valid && in_ready;
        diag_bad  = in_data[W-1] || (in_data == '0);
        beat_end  = (cnt == CW'(BEATS - 1));
        load      = ((phase == PH_EMIT) && slot_free) || ((phase == PH_ROW) && acc);
        load_last = (phase == PH_ROW) && beat_end && (idx == IW'(N - 1));
        op_a      = (phase == PH_EMIT) ? diag_q : in_data;
        isr_req   = (phase == PH_REQ);
        isr_arg   = diag_q;
        factor    = factor_q;
        pass      = pass_q;
        err       = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_DIAG;
            diag_q   <= '0;
            factor_q <= '0;
            pass_q   <= 1'b0;
            cnt      <= '0;
            idx      <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (phase)
                PH_DIAG: if (acc) begin
                    diag_q <= in_data;
                    pass_q <= diag_bad;
                    err_q  <= (idx == '0) ? diag_bad : (err_q | diag_bad);
                    phase  <= diag_bad ? PH_EMIT : PH_REQ;
                end
                PH_REQ:  phase <= PH_WAIT;
                PH_WAIT: if (isr_rsp_valid) begin
                    factor_q <= isr_rsp_data;
                    phase    <= PH_EMIT;
                end
                PH_EMIT: if (slot_free) begin
                    cnt   <= CW'(1);
                    phase <= PH_ROW;
                end
                PH_ROW: if (acc) begin
                    if (beat_end) begin
                        cnt   <= '0;
                        idx   <= (idx == IW'(N - 1)) ? '0 : idx + IW'(1);
                        phase <= PH_DIAG;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: phase <= PH_DIAG;
            endcase
        end
    end

    // R4
    isr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        isr_req |=> !isr_req);

    // R5
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(in_valid && in_ready));

endmodule

// File: rtl/sgr_rescale_obuf.sv
module sgr_rescale_obuf #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         d_last,
    input  logic         d_pass,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         slot_free,
    output logic         done
);
    logic         v_q;
    logic [W-1:0] data_q;
    logic         last_q;
    logic         pass_q;
    logic         done_q;

    assign slot_free = !v_q || out_ready;
    assign out_valid = v_q;
    assign out_data  = data_q;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            data_q <= '0;
            last_q <= 1'b0;
            pass_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= v_q && out_ready && last_q;
            if (load) begin
                v_q    <= 1'b1;
                data_q <= d;
                last_q <= d_last;
                pass_q <= d_pass;
            end else if (out_ready) begin
                v_q <= 1'b0;
            end
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (v_q && !out_ready) |=> (v_q && $stable(data_q)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(v_q && out_ready && last_q));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (v_q && !pass_q) |-> (data_q != {1'b1, {(W-1){1'b0}}}));

endmodule

// File: rtl/sgr_rescale.sv
module sgr_rescale
    import sgr_rescale_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 24,
    parameter int F = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         isr_req,
    output logic [W-1:0] isr_arg,
    input  logic         isr_rsp_valid,
    input  logic [W-1:0] isr_rsp_data,
    output logic         err,
    output logic         done
);
    logic         slot_free;
    logic [W-1:0] op_a;
    logic [W-1:0] factor;
    logic         pass;
    logic         load;
    logic         load_last;
    logic [W-1:0] scaled;

    sgr_rescale_ctrl #(.N(N), .W(W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .slot_free     (slot_free),
        .isr_req       (isr_req),
        .isr_arg       (isr_arg),
        .isr_rsp_valid (isr_rsp_valid),
        .isr_rsp_data  (isr_rsp_data),
        .op_a          (op_a),
        .factor        (factor),
        .pass          (pass),
        .load          (load),
        .load_last     (load_last),
        .err           (err)
    );

    sgr_rescale_mul #(.W(W), .F(F)) u_mul (
        .a    (op_a),
        .b    (factor),
        .pass (pass),
        .y    (scaled)
    );

    sgr_rescale_obuf #(.W(W)) u_obuf (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .d         (scaled),
        .d_last    (load_last),
        .d_pass    (pass),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .slot_free (slot_free),
        .done      (done)
    );

endmodule

// File: tb/sgr_rescale_tb.sv
module sgr_rescale_tb;
    localparam int N       = 3;
    localparam int W       = 24;
    localparam int F       = 12;
    localparam int ISR_LAT = 12;
    localparam int MAXV    = (1 << (W - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;
    logic         isr_req;
    logic [W-1:0] isr_arg;
    logic         isr_rsp_valid = 1'b0;
    logic [W-1:0] isr_rsp_data = '0;
    logic         err;
    logic         done;

    always #2 clk = ~clk;

    sgr_rescale #(.N(N), .W(W), .F(F)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .isr_req(isr_req), .isr_arg(isr_arg),
        .isr_rsp_valid(isr_rsp_valid), .isr_rsp_data(isr_rsp_data),
        .err(err), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    int in_v[$];
    bit in_diag[$];
    bit in_first[$];
    int exp_v[$];
    bit exp_last[$];
    int exp_kind[$];
    int exp_arg[$];

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int isr_fn(input int x);
        real r;
        int  y;
        r = (2.0 ** F) / $sqrt(real'(x) / (2.0 ** F));
        y = $rtoi(r + 0.5);
        if (y > MAXV) y = MAXV;
        return y;
    endfunction

    function automatic longint raw_prod(input int v, input int f);
        return (longint'(v) * longint'(f) + (longint'(1) <<< (F - 1))) >>> F;
    endfunction

    function automatic int scale_fn(input int v, input int f);
        longint p;
        p = raw_prod(v, f);
        if (p > MAXV) p = MAXV;
        if (p < -MAXV) p = -MAXV;
        return int'(p);
    endfunction

    function automatic int kind_of(input int v, input int f, input bit diag);
        longint p;
        longint full;
        p    = raw_prod(v, f);
        full = longint'(v) * longint'(f);
        if (p > MAXV || p < -MAXV) return 7;
        if ((full & ((longint'(1) <<< F) - 1)) == (longint'(1) <<< (F - 1))) return 6;
        return diag ? 2 : 3;
    endfunction

    task automatic add_index(input int idx, input int d, input int base, input int step);
        int  f;
        bit  byp;
        int  v;
        byp = (d <= 0);
        f   = byp ? 0 : isr_fn(d);
        in_v.push_back(d);
        in_diag.push_back(1'b1);
        in_first.push_back(idx == 0);
        exp_v.push_back(byp ? d : scale_fn(d, f));
        exp_last.push_back(1'b0);
        exp_kind.push_back(byp ? 5 : kind_of(d, f, 1'b1));
        if (!byp) exp_arg.push_back(d);
        for (int k = 0; k < 2*N - 1; k++) begin
            v = base + k * step;
            in_v.push_back(v);
            in_diag.push_back(1'b0);
            in_first.push_back(1'b0);
            exp_v.push_back(byp ? v : scale_fn(v, f));
            exp_last.push_back((k == 2*N - 2) && (idx == N - 1));
            exp_kind.push_back(byp ? 5 : kind_of(v, f, 1'b0));
        end
    endtask

    function automatic string tag(input int k);
        case (k)
            2: return "R2";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R3";
        endcase
    endfunction

    initial begin
        int  cyc;
        bit  prev_in_acc;
        bit  err_m;
        bit  done_m;
        bit  isr_pend;
        int  isr_cd;
        int  isr_arg_q;
        bit  stalled;
        int  stall_data;
        int  idle;
        bit  nonpos;

        // Matrix A: rounding ties and ordinary scaling
        add_index(0, 16384, -3, 1);
        add_index(1, 9216, 1000, -700);
        add_index(2, 4096, -40000, 25000);
        // Matrix B: zero and negative diagonals mid-matrix
        add_index(0, 8192, 5, 3);
        add_index(1, 0, -77, 11);
        add_index(2, -500, 123456, -1);
        // Matrix C: saturation both ways
        add_index(0, 1, MAXV, 0);
        add_index(1, 1, -MAXV, 0);
        add_index(2, 4, -200, 100);
        // Matrix D: bad first diagonal
        add_index(0, -1, 7, 7);
        add_index(1, 12000, 3333, -1234);
        add_index(2, 50, 10, 1);
        // Matrix E: error flag clears
        add_index(0, 20000, 1, 2);
        add_index(1, 3000, -5000, 1700);
        add_index(2, 100000, 64, -32);

        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(done == 1'b0, "R10", done, 0);
        check(err == 1'b0, "R10", err, 0);
        check(isr_req == 1'b0, "R10", isr_req, 0);
        check(in_ready == 1'b1, "R10", in_ready, 1);
        @(negedge clk);
        rst = 1'b0;

        cyc = 0; prev_in_acc = 0; err_m = 0; done_m = 0;
        isr_pend = 0; isr_cd = 0; isr_arg_q = 0; stalled = 0; stall_data = 0; idle = 0;

        while (idle < 20) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "R1 watchdog", cyc, 20000);
                break;
            end
            // drive
            if (!in_valid || prev_in_acc) begin
                in_valid = (in_v.size() > 0) && (cyc % 7 != 2);
                in_data  = in_valid ? W'(in_v[0]) : '0;
            end
            out_ready = (cyc % 5 != 3) && !(cyc >= 300 && cyc < 330);
            isr_rsp_valid = 1'b0;
            if (isr_pend) begin
                isr_cd--;
                if (isr_cd == 0) begin
                    isr_rsp_valid = 1'b1;
                    isr_rsp_data  = W'(isr_fn(isr_arg_q));
                    isr_pend      = 0;
                end
            end
            #1;
            // compare registered outputs
            check(err == err_m, "R5 err", err, err_m);
            check(done == done_m, "R8 done", done, done_m);
            if (stalled) begin
                check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
                check($signed(out_data) == stall_data, "R9 data held", $signed(out_data), stall_data);
            end
            stalled = out_valid && !out_ready;
            stall_data = $signed(out_data);

            done_m = 0;
            if (out_valid && out_ready) begin
                if (exp_v.size() == 0) begin
                    check(1'b0, "R1 extra beat", $signed(out_data), 0);
                end else begin
                    check($signed(out_data) == exp_v[0], tag(exp_kind[0]), $signed(out_data), exp_v[0]);
                    done_m = exp_last[0];
                    void'(exp_v.pop_front());
                    void'(exp_last.pop_front());
                    void'(exp_kind.pop_front());
                end
            end
            prev_in_acc = in_valid && in_ready;
            if (prev_in_acc) begin
                if (in_diag[0]) begin
                    nonpos = (in_v[0] <= 0);
                    err_m  = in_first[0] ? nonpos : (err_m | nonpos);
                end
                void'(in_v.pop_front());
                void'(in_diag.pop_front());
                void'(in_first.pop_front());
            end
            if (isr_req) begin
                check(in_ready == 1'b0, "R4 stall on request", in_ready, 0);
                if (exp_arg.size() == 0) begin
                    check(1'b0, "R4 unexpected request", $signed(isr_arg), 0);
                end else begin
                    check($signed(isr_arg) == exp_arg[0], "R4 argument", $signed(isr_arg), exp_arg[0]);
                    void'(exp_arg.pop_front());
                end
                isr_pend  = 1;
                isr_cd    = ISR_LAT;
                isr_arg_q = $signed(isr_arg);
            end
            if (in_v.size() == 0 && exp_v.size() == 0) idle++;
        end

        check(exp_arg.size() == 0, "R4 request count", exp_arg.size(), 0);
        check(exp_v.size() == 0, "R1 beats emitted", exp_v.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule